// File: doc/BRIEF.md
# Duplex Pump Alternation Controller

The controller runs the two pumps of a wet well, one east and one west, from three level floats: low, high and very high. The floats form three bands with hysteresis. Below the low float both pumps stop. At the high float the current duty pump starts. At the very-high float both pumps start. Between the low and high floats, each pump keeps the state it had. In MANUAL mode each pump follows its own local pushbutton instead of the float bands. The low-float stop still applies in MANUAL.

The duty pump is taken from the parity of an alternation count. The count advances each time accumulated run time reaches a calendar preset. Run time is counted in single-cycle ticks, for example one per hour. A tick counts only in AUTO mode, and only while the duty pump runs alone. The preset is captured from an input in the single initialization cycle that follows reset release. That cycle also clears the counters and both commands.

Top module: `duplex_pump_ctrl`

## Requirements
- R1: In the cycle after `lvl_low` is 0, both `run_east` and `run_west` are 0. This holds in either mode and whatever the higher floats show.
- R2: In AUTO (`auto_sel`=1), with `lvl_low`=1, `lvl_high`=1 and `lvl_vhigh`=0, the duty pump's command is 1 in the next cycle and the other command is unchanged. The duty pump is east when `duty_west` is 0 and west when it is 1.
- R3: In AUTO, with `lvl_low`=1 and `lvl_vhigh`=1, both commands are 1 in the next cycle.
- R4: In AUTO, with `lvl_low`=1, `lvl_high`=0 and `lvl_vhigh`=0, both commands keep their values.
- R5: `duty_west` is bit 0 of an alternation count. The count is 0 after initialization. It increments when a counted tick brings the accumulated tick count up to the preset, and the tick count then restarts at 0. A preset of 0 acts as 1. `duty_west` changes only in the cycle after a `run_tick` pulse.
- R6: A `run_tick` pulse is counted only in AUTO, only while the duty pump's command is 1, and only while the other command is 0. When both pumps run, accumulation is frozen.
- R7: In the first cycle after `rst_n` rises, `cal_preset` is captured and the counts are cleared. In the next cycle the outputs are all 0. Later changes of `cal_preset` have no effect until the next reset.
- R8: In MANUAL (`auto_sel`=0), each command in the next cycle equals its pushbutton ANDed with `lvl_low`. Ticks are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lvl_low | input | 1 | Low-level float, 1 = water above it |
| lvl_high | input | 1 | High-level float |
| lvl_vhigh | input | 1 | Very-high-level float |
| auto_sel | input | 1 | 1 = AUTO, 0 = MANUAL |
| pb_east | input | 1 | East local start pushbutton (MANUAL) |
| pb_west | input | 1 | West local start pushbutton (MANUAL) |
| run_tick | input | 1 | One-cycle run-time unit pulse |
| cal_preset | input | CAL_W | Calendar length in ticks, captured at initialization |
| run_east | output | 1 | East pump run command |
| run_west | output | 1 | West pump run command |
| duty_west | output | 1 | 1 = west pump is the duty pump |

## Verification
A wrong tick count or alternation count is never visible directly. It appears only as `duty_west` toggling after the wrong tick pulse. It can then also appear as the wrong pump starting at the next high-float event. A wrong latch state in a command shows in the very next cycle on `run_east` or `run_west`. The reference model is compared on every clock, so a mismatch is reported in the cycle it first reaches a port.

// File: rtl/duplex_pump_ctrl.sv
module duplex_pump_ctrl #(
  parameter int CAL_W = 16,
  parameter int ALT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl_low,
  input  logic             lvl_high,
  input  logic             lvl_vhigh,
  input  logic             auto_sel,
  input  logic             pb_east,
  input  logic             pb_west,
  input  logic             run_tick,
  input  logic [CAL_W-1:0] cal_preset,
  output logic             run_east,
  output logic             run_west,
  output logic             duty_west
);

  logic             init_q;
  logic [CAL_W-1:0] preset_q;
  logic [CAL_W-1:0] acc_q;
  logic [ALT_W-1:0] alt_q;
  logic             e_q, w_q;
  logic             e_d, w_d;

  logic duty_on, solo, count_en, expire;
  logic [CAL_W:0] acc_inc;

  assign duty_west = alt_q[0];
  assign run_east  = e_q;
  assign run_west  = w_q;

  assign duty_on  = duty_west ? w_q : e_q;
  assign solo     = !(e_q && w_q);
  assign count_en = auto_sel && run_tick && duty_on && solo;
  assign acc_inc  = {1'b0, acc_q} + 1'b1;
  assign expire   = acc_inc >= {1'b0, preset_q};

  always_comb begin
    e_d = e_q;
    w_d = w_q;
    if (!lvl_low) begin
      e_d = 1'b0;
      w_d = 1'b0;
    end else if (!auto_sel) begin
      e_d = pb_east;
      w_d = pb_west;
    end else if (lvl_vhigh) begin
      e_d = 1'b1;
      w_d = 1'b1;
    end else if (lvl_high) begin
      if (duty_west) w_d = 1'b1;
      else           e_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q   <= 1'b0;
      preset_q <= '0;
      acc_q    <= '0;
      alt_q    <= '0;
      e_q      <= 1'b0;
      w_q      <= 1'b0;
    end else if (!init_q) begin
      init_q   <= 1'b1;
      preset_q <= cal_preset;
      acc_q    <= '0;
      alt_q    <= '0;
      e_q      <= 1'b0;
      w_q      <= 1'b0;
    end else begin
      e_q <= e_d;
      w_q <= w_d;
      if (count_en) begin
        if (expire) begin
          acc_q <= '0;
          alt_q <= alt_q + 1'b1;
        end else begin
          acc_q <= acc_inc[CAL_W-1:0];
        end
      end
    end
  end

endmodule

// File: rtl/duplex_pump_ctrl_chk.sv
module duplex_pump_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic init_q,
  input logic lvl_low,
  input logic lvl_high,
  input logic lvl_vhigh,
  input logic auto_sel,
  input logic pb_east,
  input logic pb_west,
  input logic run_tick,
  input logic run_east,
  input logic run_west,
  input logic duty_west
);

  assert_low_stop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !lvl_low |=> (!run_east && !run_west));

  assert_duty_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (init_q && auto_sel && lvl_low && lvl_high && !lvl_vhigh)
    |=> ($past(duty_west) ? (run_west && $stable(run_east))
                          : (run_east && $stable(run_west))));

  assert_both_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (init_q && auto_sel && lvl_low && lvl_vhigh) |=> (run_east && run_west));

  assert_hold_band_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (init_q && auto_sel && lvl_low && !lvl_high && !lvl_vhigh)
    |=> ($stable(run_east) && $stable(run_west)));

  assert_duty_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (init_q && !run_tick) |=> $stable(duty_west));

  assert_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (init_q && run_east && run_west) |=> $stable(duty_west));

  assert_init_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !init_q |=> (!run_east && !run_west && !duty_west));

  assert_manual_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (init_q && !auto_sel) |=> (run_east == $past(pb_east && lvl_low) &&
                               run_west == $past(pb_west && lvl_low) &&
                               $stable(duty_west)));

endmodule

bind duplex_pump_ctrl duplex_pump_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .init_q(init_q),
  .lvl_low(lvl_low), .lvl_high(lvl_high), .lvl_vhigh(lvl_vhigh),
  .auto_sel(auto_sel), .pb_east(pb_east), .pb_west(pb_west),
  .run_tick(run_tick), .run_east(run_east), .run_west(run_west),
  .duty_west(duty_west)
);

// File: tb/duplex_pump_ctrl_tb.sv
`timescale 1ns/1ps
module duplex_pump_ctrl_tb;
  localparam int CAL_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lvl_low = 0, lvl_high = 0, lvl_vhigh = 0, auto_sel = 1;
  logic pb_east = 0, pb_west = 0, run_tick = 0;
  logic [CAL_W-1:0] cal_preset = '0;
  logic run_east, run_west, duty_west;

  always #5 clk = ~clk;

  duplex_pump_ctrl #(.CAL_W(CAL_W), .ALT_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .lvl_low(lvl_low), .lvl_high(lvl_high),
    .lvl_vhigh(lvl_vhigh), .auto_sel(auto_sel), .pb_east(pb_east),
    .pb_west(pb_west), .run_tick(run_tick), .cal_preset(cal_preset),
    .run_east(run_east), .run_west(run_west), .duty_west(duty_west)
  );

  int checks = 0, fails = 0, cycles = 0;
  string req = "R7";
  bit done = 0;

  // behavioural reference
  bit m_init = 0, m_e = 0, m_w = 0;
  int m_alt = 0, m_acc = 0, m_preset = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_init = 0; m_e = 0; m_w = 0; m_alt = 0; m_acc = 0; m_preset = 0;
    end else if (!m_init) begin
      m_init = 1; m_preset = int'(cal_preset); m_alt = 0; m_acc = 0;
      m_e = 0; m_w = 0;
    end else begin
      bit dw, ne, nw;
      dw = m_alt[0];
      ne = m_e; nw = m_w;
      if (!lvl_low) begin ne = 0; nw = 0; end
      else if (!auto_sel) begin ne = pb_east; nw = pb_west; end
      else if (lvl_vhigh) begin ne = 1; nw = 1; end
      else if (lvl_high) begin if (dw) nw = 1; else ne = 1; end
      if (auto_sel && run_tick && (dw ? m_w : m_e) && !(m_e && m_w)) begin
        m_acc++;
        if (m_acc >= ((m_preset == 0) ? 1 : m_preset)) begin
          m_acc = 0; m_alt++;
        end
      end
      m_e = ne; m_w = nw;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      cycles++;
      checks++;
      if (run_east !== m_e || run_west !== m_w || duty_west !== m_alt[0]) begin
        fails++;
        $display("FAIL %s cycle %0d: actual e=%b w=%b d=%b expected e=%b w=%b d=%b",
                 req, cycles, run_east, run_west, duty_west, m_e, m_w, m_alt[0]);
      end
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
    end
  endtask

  task automatic tick();
    run_tick = 1; step(1); run_tick = 0; step(1);
  endtask

  task automatic do_reset(input int p);
    rst_n = 0; cal_preset = CAL_W'(p); step(2);
    rst_n = 1; req = "R7"; step(1);
    cal_preset = CAL_W'(p + 5); step(2);
  endtask

  initial begin
    #2;
    do_reset(3);                                // R7 preset 3, then changed
    req = "R2"; lvl_low = 1; lvl_high = 1; step(2);      // east starts
    req = "R4"; lvl_high = 0; step(3);                   // hold on
    req = "R5"; for (int i = 0; i < 3; i++) tick();      // 3 ticks -> west duty
    req = "R4"; step(2);                                  // east still held
    req = "R1"; lvl_low = 0; step(2);                    // stop
    req = "R2"; lvl_low = 1; lvl_high = 1; step(2);      // west starts
    req = "R6"; lvl_vhigh = 1; step(2);                  // both on
    for (int i = 0; i < 4; i++) tick();                  // R6 frozen
    req = "R4"; lvl_vhigh = 0; lvl_high = 0; step(2);
    req = "R1"; lvl_low = 0; lvl_high = 1; lvl_vhigh = 1; step(3); // inconsistent
    req = "R5"; lvl_low = 1; lvl_vhigh = 0; step(2);     // west duty starts
    for (int i = 0; i < 3; i++) tick();                  // back to east
    req = "R8"; auto_sel = 0; pb_east = 1; pb_west = 0; step(2);
    tick(); tick(); tick();                              // R8 ticks ignored
    pb_west = 1; step(2);
    lvl_low = 0; step(2);                                // R8 low gate
    lvl_low = 1; pb_east = 0; step(2);
    req = "R6"; auto_sel = 1; lvl_high = 0; tick(); tick(); tick(); // off-duty west
    do_reset(0);                                         // R7 and R5 preset 0
    req = "R5"; lvl_low = 1; lvl_high = 1; step(2);
    tick(); tick();
    lvl_high = 0; tick();
    req = "R3"; lvl_vhigh = 1; step(2);
    req = "R1"; lvl_low = 0; step(2);
    step(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule